// File: doc/BRIEF.md
# Fixed-Point 8x8 Forward DCT Coprocessor

This block is a bus-attached accelerator that applies a two-dimensional forward discrete cosine transform to an 8x8 tile of signed 8-bit samples. All arithmetic is integer. Cosine weights carry six fractional bits, and every product is rescaled before it is accumulated. A fixed normalisation step ends the chain. The block has a byte-wide register port with four addresses.

A host uses the block in four steps. It writes 64 samples to the push register and writes 1 to the command register. It then reads the status register until it drops to 0, and reads the 64 coefficients back from the pop register as byte pairs. The transform runs sequentially on a single multiply-accumulate path, so the block is small and its run time is fixed.

Top module: `dct8_copro`

## Requirements
- R1: After reset the status register reads 0, and the pop register returns zero bytes.
- R2: A write to address 2 takes the byte as a signed value, multiplies it by 64 and stores it at the current sample slot. Slot n is row n/8, column n%8. The slot counter steps by one and wraps from 63 to 0, so later pushes overwrite the earliest entries.
- R3: The weight w(k,n) equals 64·cos((2k+1)·n·π/16), truncated toward zero. Its magnitudes are taken from {64,62,59,53,45,35,24,12}, and n=0 gives 64.
- R4: Output (u,v) is computed in three steps. First, each row sum s[x] = Σj (in[x][j]·w(j,v)) >> 6. Then r = Σx (s[x]·w(x,u)) >> 6. Finally the result is (r·q(u)·c(v)) >> 18, truncated to 16 bits. Here q is 1 for index 0 and 16 otherwise, c is 5 for index 0 and 64 otherwise, and every shift is arithmetic and applied before each addition.
- R5: Results leave in the order u-major, v-minor: the k-th result popped is output (k/8, k%8).
- R6: The register map is 0 = status (bit 0 busy, other bits 0), 1 = command, 2 = sample push, 3 = result pop. Reads of addresses 1 and 2 return 0.
- R7: Writing exactly 1 to the command register while idle starts a transform. It also clears the push slot counter, the pop pointer and the byte phase. Any other command value leaves the block idle.
- R8: Status reads 1 from the cycle after the starting write. It stays at 1 for exactly 4672 cycles, which is 73 per output.
- R9: While busy, command writes and pushes are ignored, and reads of address 3 do not move the pop pointer.
- R10: Each result is popped as two reads: the high byte first, then the low byte. The pointer advances after the low byte and wraps from 63 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe for the current cycle |
| rd_en | input | 1 | Read strobe; the side effects of a pop take place at the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr and state |

## Verification
Read data is combinational, so the bench samples it shortly after driving the address in mid-cycle, before the edge that commits any pop step. Status is first due in the cycle following the edge that captures the command. The bench counts one cycle per bus access from that point and expects the first zero at count 4672, including the accesses it makes while the block is busy. Coefficients are compared only after status has dropped, against a bench model that uses cosines computed in floating point and the shift chain from R4.

// File: rtl/dct8_copro.sv
module dct8_copro (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam logic [1:0] A_STAT = 2'd0, A_CMD = 2'd1, A_PUSH = 2'd2, A_POP = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_MAC, S_FOLD, S_FIN} st_t;
  st_t st;

  logic signed [15:0] in_buf  [64];
  logic signed [15:0] out_buf [64];
  logic [5:0] push_idx, pop_ptr;
  logic       pop_lo, busy;
  logic [2:0] u, v, x, j;
  logic signed [31:0] s_acc, r_acc, mac_p, fold_p;
  logic signed [11:0] kscale;
  logic signed [47:0] fin_p;
  logic signed [15:0] fin_q;

  function automatic logic signed [7:0] cosq(input logic [2:0] k, input logic [2:0] n);
    logic [4:0] m, f;
    logic       neg;
    logic signed [7:0] mag;
    m = 5'({1'b0, k, 1'b1} * {2'b0, n});
    f = (m > 5'd16) ? 5'd0 - m : m;
    neg = (f > 5'd8);
    if (neg) f = 5'd16 - f;
    case (f)
      5'd0: mag = 8'sd64;
      5'd1: mag = 8'sd62;
      5'd2: mag = 8'sd59;
      5'd3: mag = 8'sd53;
      5'd4: mag = 8'sd45;
      5'd5: mag = 8'sd35;
      5'd6: mag = 8'sd24;
      5'd7: mag = 8'sd12;
      default: mag = 8'sd0;
    endcase
    return neg ? -mag : mag;
  endfunction

  assign busy   = (st != S_IDLE);
  assign mac_p  = 32'(in_buf[{x, j}]) * 32'(cosq(j, v));
  assign fold_p = s_acc * 32'(cosq(x, u));
  assign kscale = ((u == 3'd0) ? 12'sd1 : 12'sd16) * ((v == 3'd0) ? 12'sd5 : 12'sd64);
  assign fin_p  = 48'(r_acc) * 48'(kscale);
  assign fin_q  = 16'(fin_p >>> 18);

  always_comb begin
    case (addr)
      A_STAT:  rdata = {7'b0, busy};
      A_POP:   rdata = pop_lo ? out_buf[pop_ptr][7:0] : out_buf[pop_ptr][15:8];
      default: rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {u, v, x, j} <= '0;
      push_idx <= '0;
      pop_ptr  <= '0;
      pop_lo   <= 1'b0;
      s_acc    <= '0;
      r_acc    <= '0;
      for (int i = 0; i < 64; i++) begin
        in_buf[i]  <= '0;
        out_buf[i] <= '0;
      end
    end else begin
      case (st)
        S_IDLE: begin
          if (wr_en && addr == A_PUSH) begin
            in_buf[push_idx] <= 16'($signed(wdata)) <<< 6;
            push_idx <= push_idx + 6'd1;
          end
          if (wr_en && addr == A_CMD && wdata == 8'd1) begin
            st <= S_MAC;
            {u, v, x, j} <= '0;
            s_acc <= '0;
            r_acc <= '0;
            push_idx <= '0;
            pop_ptr  <= '0;
            pop_lo   <= 1'b0;
          end
          if (rd_en && addr == A_POP) begin
            pop_lo <= !pop_lo;
            if (pop_lo) pop_ptr <= pop_ptr + 6'd1;
          end
        end
        S_MAC: begin
          s_acc <= s_acc + (mac_p >>> 6);
          j <= j + 3'd1;
          if (j == 3'd7) st <= S_FOLD;
        end
        S_FOLD: begin
          r_acc <= r_acc + (fold_p >>> 6);
          s_acc <= '0;
          x <= x + 3'd1;
          st <= (x == 3'd7) ? S_FIN : S_MAC;
        end
        S_FIN: begin
          out_buf[{u, v}] <= fin_q;
          r_acc <= '0;
          v <= v + 3'd1;
          if (v == 3'd7) u <= u + 3'd1;
          st <= (u == 3'd7 && v == 3'd7) ? S_IDLE : S_MAC;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dct8_copro_chk.sv
module dct8_copro_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] addr,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wdata,
  input logic       busy,
  input logic [5:0] push_idx,
  input logic [5:0] pop_ptr,
  input logic       pop_lo
);
  logic [15:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 16'd1;
    else           run_cnt <= '0;
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && addr == 2'd1 && wdata == 8'd1) |=> busy); // R7
  AST_BAD_CMD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && addr == 2'd1 && wdata != 8'd1) |=> !busy); // R7
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && addr == 2'd2) |=> push_idx == $past(push_idx) + 6'd1); // R2
  AST_BUSY_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(push_idx)); // R9
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && rd_en && addr == 2'd3 && pop_lo) |=> (pop_ptr == $past(pop_ptr) + 6'd1 && !pop_lo)); // R10
  AST_BUSY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(pop_ptr) && $stable(pop_lo))); // R9
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_cnt == 16'd4672); // R8
endmodule

bind dct8_copro dct8_copro_chk i_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .busy(busy), .push_idx(push_idx), .pop_ptr(pop_ptr), .pop_lo(pop_lo)
);

// File: tb/test_dct8_copro.sv
module test_dct8_copro;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dct8_copro i_dct8_copro (.*);

  longint m_in [64];
  int     m_idx = 0;
  logic [15:0] ref_out [64];

  function automatic longint wref(int k, int n);
    return longint'($rtoi(64.0 * $cos(real'((2 * k + 1) * n) * 3.14159265358979 / 16.0)));
  endfunction

  task automatic compute_ref();
    for (int u = 0; u < 8; u++)
      for (int v = 0; v < 8; v++) begin
        longint r = 0, k;
        for (int x = 0; x < 8; x++) begin
          longint s = 0;
          for (int jj = 0; jj < 8; jj++) s += (m_in[x * 8 + jj] * wref(jj, v)) >>> 6;
          r += (s * wref(x, u)) >>> 6;
        end
        k = ((16 * ((u != 0) ? 64 : 5)) >> 6) * ((v != 0) ? 64 : 5);
        ref_out[u * 8 + v] = 16'((r * k) >>> 18);
      end
  endtask

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #2 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    m_in[m_idx] = longint'($signed(b)) <<< 6;
    m_idx = (m_idx + 1) % 64;
    wr(2'd2, b);
  endtask

  task automatic pop16(output logic [15:0] w);
    logic [7:0] h, l;
    rd(2'd3, h);
    rd(2'd3, l);
    w = {h, l};
  endtask

  task automatic run_block(string tag, bit disturb);
    int el = 0;
    logic [7:0] d;
    logic [15:0] w;
    int bad = 0;
    wr(2'd1, 8'd1);
    m_idx = 0;
    if (disturb) begin
      for (int i = 0; i < 3; i++) begin wr(2'd2, 8'h55); el++; end
      wr(2'd1, 8'd1); el++;
      rd(2'd3, d); el++;
      rd(2'd3, d); el++;
      wr(2'd1, 8'd2); el++;
    end
    forever begin
      rd(2'd0, d);
      if (d == 8'd0) break;
      el++;
      if (el > 6000) break;
    end
    chk({tag, " R8 busy cycles"}, el, 4672);
    compute_ref();
    for (int k = 0; k < 64; k++) begin
      pop16(w);
      if (w != ref_out[k]) begin
        bad++;
        $display("FAIL %s R4 R5 result %0d actual=%0d expected=%0d", tag, k,
                 $signed(w), $signed(ref_out[k]));
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  initial begin
    logic [7:0] d;
    logic [15:0] w;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(2'd0, d); chk("R1 status after reset", d, 0);
    pop16(w);    chk("R1 pop after reset", w, 0);
    rd(2'd1, d); chk("R6 command reads zero", d, 0);
    rd(2'd2, d); chk("R6 push reads zero", d, 0);
    wr(2'd1, 8'd2); rd(2'd0, d); chk("R7 command 2 ignored", d, 0);
    wr(2'd1, 8'd0); rd(2'd0, d); chk("R7 command 0 ignored", d, 0);

    for (int i = 0; i < 64; i++) push(8'd127);
    run_block("flat 127 with busy traffic R9", 1'b1);
    pop16(w); chk("R10 pop pointer wrap", w, ref_out[0]);

    run_block("rerun R9 R7 buffer untouched", 1'b0);

    for (int i = 0; i < 64; i++) push(8'($urandom));
    run_block("random R3 R4", 1'b0);

    for (int i = 0; i < 64; i++) push(8'h80);
    run_block("all -128 R2 sign", 1'b0);

    for (int i = 0; i < 70; i++) push(8'($urandom));
    run_block("70 pushes R2 wrap", 1'b0);

    for (int i = 0; i < 64; i++) begin
      logic [7:0] mg;
      mg = 8'($urandom % 100);
      push((((i / 8) + (i % 8)) % 2 == 1) ? 8'(-mg) : mg);
    end
    run_block("checkerboard R3 R5", 1'b0);

    for (int i = 0; i < 64; i++) push((i == 9) ? 8'd100 : 8'd0);
    run_block("single impulse R3", 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule